// File: doc/BRIEF.md
# Outstanding Memory Request Buffer

This block sits between a second-level cache and the memory system. It collects requests from the cache side. Each request carries a block address and one of three kinds: read miss, prefetch or write. The block offers them to memory one at a time over a valid/ready port. An entry leaves the buffer when memory returns a reply for its block. The block never has two requests to the same block in flight at once. A later request to a block that is already busy waits in the buffer without being issued.

Read misses are latency-critical, so a read miss may be issued ahead of older writes to other blocks. Order among requests to the same block is always kept. A combinational lookup port tells neighbouring logic whether a block already has an entry, so that logic can skip redundant prefetches. Prefetch replies come in two kinds: one carries data, the other is negative and says the block was in a transient state. Either kind completes the entry.

Top module: `pend_req_buf`

## Requirements
- R1: Kind encoding on `req_kind_i` and `mem_kind_o` is 2'b00 read miss, 2'b01 prefetch, 2'b10 write. An issued request shows the same address and kind that were accepted for it.
- R2: At no time are two issued, unretired entries held for the same block address.
- R3: A request to a block that already has an issued request stays unissued until a reply for that block arrives. After the reply it becomes eligible to issue.
- R4: A read miss is issued ahead of older queued writes to other blocks.
- R5: A read miss never issues ahead of an older entry to the same block.
- R6: A reply with `rsp_neg_i` at 0 (data) or at 1 (negative) retires the issued entry of its block, and `look_hit_o` then drops for that block.
- R7: `look_hit_o` is high in the same cycle when any held entry, issued or not, has the block address on `look_addr_i`.
- R8: `req_ready_o` is low while DEPTH entries are held. While it is low, an offered request is not taken. It rises again in the cycle after a retirement.
- R9: Among eligible entries, the oldest read miss is chosen first. When no read miss is eligible, the oldest other eligible entry is chosen, in arrival order.
- R10: After reset the buffer is empty: `req_ready_o` is high, and `mem_valid_o` and `look_hit_o` are low.
- R11: A reply for a block with no issued entry changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Cache-side request offered |
| req_ready_o | output | 1 | Buffer has a free slot |
| req_addr_i | input | AW | Block address of the request |
| req_kind_i | input | 2 | Request kind |
| mem_valid_o | output | 1 | A request is offered to memory |
| mem_ready_i | input | 1 | Memory takes the offered request |
| mem_addr_o | output | AW | Block address of the offered request |
| mem_kind_o | output | 2 | Kind of the offered request |
| rsp_valid_i | input | 1 | Reply from memory |
| rsp_addr_i | input | AW | Block address of the reply |
| rsp_neg_i | input | 1 | Reply is negative (no data) |
| look_addr_i | input | AW | Block address queried |
| look_hit_o | output | 1 | Queried block has an entry |

## Verification
The assertions assume three things about the inputs. Memory replies only for blocks it has taken and not yet answered. `req_kind_i` never carries 2'b11. A reply never arrives in the same cycle as the issue it answers. The bench keeps to all three: it sends each reply only after the matching issue handshake, it uses only the three defined kinds, and it drives every input at the falling edge. Issue order and retirement are checked against orders worked out by hand for sweeps over write counts ahead of a read, for same-block pairs, and for a full fill and drain.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_PREF  = 2'b01,
    KIND_WRITE = 2'b10
  } req_kind_e;
endpackage

// File: rtl/pr_match.sv
module pr_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr_i,
  input  logic [DEPTH-1:0]         ent_valid_i,
  input  logic [AW-1:0]            key_i,
  output logic [DEPTH-1:0]         hit_vec_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec_o[i] = ent_valid_i[i] && (ent_addr_i[i] == key_i);
  end
endmodule

// File: rtl/pr_store.sv
module pr_store
  import pr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         alloc_oh_i,
  input  logic [AW-1:0]            alloc_addr_i,
  input  logic [1:0]               alloc_kind_i,
  input  logic [DEPTH-1:0]         issue_oh_i,
  input  logic [DEPTH-1:0]         retire_oh_i,
  output logic [DEPTH-1:0]         valid_o,
  output logic [DEPTH-1:0]         issued_o,
  output logic [DEPTH-1:0][AW-1:0] addr_o,
  output logic [DEPTH-1:0][1:0]    kind_o,
  output logic [DEPTH-1:0][DEPTH-1:0] older_o
);
  logic [DEPTH-1:0]            valid_q, issued_q;
  logic [DEPTH-1:0][AW-1:0]    addr_q;
  logic [DEPTH-1:0][1:0]       kind_q;
  // older_q[i][j]: entry j arrived before entry i
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      issued_q <= '0;
      addr_q   <= '0;
      kind_q   <= '0;
      older_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_oh_i[i]) begin
          valid_q[i]  <= 1'b1;
          issued_q[i] <= 1'b0;
          addr_q[i]   <= alloc_addr_i;
          kind_q[i]   <= alloc_kind_i;
          older_q[i]  <= valid_q & ~retire_oh_i;
        end else begin
          if (retire_oh_i[i]) begin
            valid_q[i]  <= 1'b0;
            issued_q[i] <= 1'b0;
          end else if (issue_oh_i[i]) begin
            issued_q[i] <= 1'b1;
          end
          older_q[i] <= older_q[i] & ~alloc_oh_i;
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign issued_o = issued_q;
  assign addr_o   = addr_q;
  assign kind_o   = kind_q;
  assign older_o  = older_q;
endmodule

// File: rtl/pr_sched.sv
module pr_sched
  import pr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0]            issued_i,
  input  logic [DEPTH-1:0][AW-1:0]    addr_i,
  input  logic [DEPTH-1:0][1:0]       kind_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  output logic [DEPTH-1:0]            grant_oh_o,
  output logic                        grant_any_o
);
  logic [DEPTH-1:0] elig, elig_rd, elig_ot, pick_rd, pick_ot;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        // same block busy in memory, or an older entry to it still waits
        if (j != i && valid_i[j] && addr_i[j] == addr_i[i] &&
            (issued_i[j] || older_i[i][j]))
          blk = 1'b1;
      end
      elig[i]    = valid_i[i] && !issued_i[i] && !blk;
      elig_rd[i] = elig[i] && (kind_i[i] == KIND_READ);
      elig_ot[i] = elig[i] && (kind_i[i] != KIND_READ);
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      pick_rd[i] = elig_rd[i];
      pick_ot[i] = elig_ot[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (elig_rd[j] && older_i[i][j]) pick_rd[i] = 1'b0;
        if (elig_ot[j] && older_i[i][j]) pick_ot[i] = 1'b0;
      end
    end
  end

  assign grant_oh_o  = (|elig_rd) ? pick_rd : pick_ot;
  assign grant_any_o = |elig;
endmodule

// File: rtl/pend_req_buf.sv
module pend_req_buf
  import pr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_kind_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_kind_o,
  input  logic          rsp_valid_i,
  input  logic [AW-1:0] rsp_addr_i,
  input  logic          rsp_neg_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          look_hit_o
);
  logic [DEPTH-1:0]            ent_valid, ent_issued;
  logic [DEPTH-1:0][AW-1:0]    ent_addr;
  logic [DEPTH-1:0][1:0]       ent_kind;
  logic [DEPTH-1:0][DEPTH-1:0] ent_older;
  logic [DEPTH-1:0]            free_oh, alloc_oh, grant_oh, issue_oh, retire_oh;
  logic [DEPTH-1:0]            rsp_hits, look_hits;
  logic                        grant_any;
  logic                        rsp_kind_unused;

  // data and negative replies retire alike
  assign rsp_kind_unused = rsp_neg_i;

  always_comb begin
    free_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_oh = DEPTH'(1) << i;
    end
  end

  assign req_ready_o = |free_oh;
  assign alloc_oh    = (req_valid_i && req_ready_o) ? free_oh : '0;

  pr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_oh_i  (alloc_oh),
    .alloc_addr_i(req_addr_i),
    .alloc_kind_i(req_kind_i),
    .issue_oh_i  (issue_oh),
    .retire_oh_i (retire_oh),
    .valid_o     (ent_valid),
    .issued_o    (ent_issued),
    .addr_o      (ent_addr),
    .kind_o      (ent_kind),
    .older_o     (ent_older)
  );

  pr_sched #(.DEPTH(DEPTH), .AW(AW)) u_sched (
    .valid_i    (ent_valid),
    .issued_i   (ent_issued),
    .addr_i     (ent_addr),
    .kind_i     (ent_kind),
    .older_i    (ent_older),
    .grant_oh_o (grant_oh),
    .grant_any_o(grant_any)
  );

  pr_match #(.DEPTH(DEPTH), .AW(AW)) u_rsp_match (
    .ent_addr_i (ent_addr),
    .ent_valid_i(ent_valid & ent_issued),
    .key_i      (rsp_addr_i),
    .hit_vec_o  (rsp_hits)
  );

  pr_match #(.DEPTH(DEPTH), .AW(AW)) u_look_match (
    .ent_addr_i (ent_addr),
    .ent_valid_i(ent_valid),
    .key_i      (look_addr_i),
    .hit_vec_o  (look_hits)
  );

  assign retire_oh  = rsp_valid_i ? rsp_hits : '0;
  assign look_hit_o = |look_hits;

  assign mem_valid_o = grant_any;
  assign issue_oh    = (mem_valid_o && mem_ready_i) ? grant_oh : '0;

  always_comb begin
    mem_addr_o = '0;
    mem_kind_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant_oh[i]) begin
        mem_addr_o = mem_addr_o | ent_addr[i];
        mem_kind_o = mem_kind_o | ent_kind[i];
      end
    end
  end
endmodule

// File: rtl/pr_chk.sv
module pr_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_ready_o,
  input logic                     mem_valid_o,
  input logic [AW-1:0]            mem_addr_o,
  input logic                     rsp_valid_i,
  input logic [DEPTH-1:0]         ent_valid,
  input logic [DEPTH-1:0]         ent_issued,
  input logic [DEPTH-1:0][AW-1:0] ent_addr
);
  logic dup_busy, has_cand, cand_busy;

  always_comb begin
    dup_busy  = 1'b0;
    has_cand  = 1'b0;
    cand_busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_valid[i] && !ent_issued[i] && ent_addr[i] == mem_addr_o) has_cand = 1'b1;
      if (ent_valid[i] && ent_issued[i] && ent_addr[i] == mem_addr_o) cand_busy = 1'b1;
      for (int j = i + 1; j < DEPTH; j++) begin
        if (ent_valid[i] && ent_issued[i] && ent_valid[j] && ent_issued[j] &&
            ent_addr[i] == ent_addr[j])
          dup_busy = 1'b1;
      end
    end
  end

  // R2
  no_dup_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup_busy);

  // R3
  offer_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (has_cand && !cand_busy));

  // R8
  full_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(ent_valid) == DEPTH) |-> !req_ready_o);

  // R8
  accept_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !rsp_valid_i) |=>
      ($countones(ent_valid) == $past($countones(ent_valid)) + 1));

  // R10
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid == '0) |-> !mem_valid_o);
endmodule

bind pend_req_buf pr_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .mem_valid_o(mem_valid_o),
  .mem_addr_o (mem_addr_o),
  .rsp_valid_i(rsp_valid_i),
  .ent_valid  (ent_valid),
  .ent_issued (ent_issued),
  .ent_addr   (ent_addr)
);

// File: tb/pend_req_buf_tb.sv
`timescale 1ns/1ps
module pend_req_buf_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam logic [1:0] RD = 2'b00, PF = 2'b01, WR = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_ready = 1'b0, rsp_valid = 1'b0, rsp_neg = 1'b0;
  logic [AW-1:0] req_addr = '0, rsp_addr = '0, look_addr = '0;
  logic [1:0] req_kind = '0;
  logic req_ready, mem_valid, look_hit;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_kind;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pend_req_buf #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_kind_i(req_kind),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_kind_o(mem_kind),
    .rsp_valid_i(rsp_valid), .rsp_addr_i(rsp_addr), .rsp_neg_i(rsp_neg),
    .look_addr_i(look_addr), .look_hit_o(look_hit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic push(input int a, input logic [1:0] k);
    req_valid = 1'b1; req_addr = AW'(a); req_kind = k;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take(input string tag, input int a, input logic [1:0] k);
    check({tag, " mem_valid"}, int'(mem_valid), 1);
    check({tag, " mem_addr"}, int'(mem_addr), a);
    check({tag, " mem_kind"}, int'(mem_kind), int'(k));
    mem_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic reply(input int a, input logic neg);
    rsp_valid = 1'b1; rsp_addr = AW'(a); rsp_neg = neg;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0; rsp_neg = 1'b0;
  endtask

  task automatic look(input string tag, input int a, input int exp);
    look_addr = AW'(a);
    #1;
    check(tag, int'(look_hit), exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check("R10 ready", int'(req_ready), 1);
    check("R10 mem_valid", int'(mem_valid), 0);
    look("R10 look_hit", 0, 0);

    // R1 R9 R7: read overtakes, others keep arrival order
    push(5, WR); push(6, WR); push(7, RD); push(8, PF);
    look("R7 hit pending 5", 5, 1);
    look("R7 miss 9", 9, 0);
    take("R9 first read", 7, RD);
    take("R9 oldest other w5", 5, WR);
    take("R9 next w6", 6, WR);
    take("R1 prefetch kind", 8, PF);
    look("R7 hit issued 8", 8, 1);
    reply(7, 1'b0); reply(5, 1'b0); reply(6, 1'b0);
    reply(8, 1'b1);
    look("R6 neg retires 8", 8, 0);
    check("R6 drained", int'(mem_valid), 0);

    // R3 R2: second request to busy block held
    push(3, RD);
    take("R3 read 3", 3, RD);
    push(3, PF);
    check("R3 held while busy", int'(mem_valid), 0);
    look("R7 held hit", 3, 1);
    reply(3, 1'b0);
    take("R3 released after reply", 3, PF);
    reply(3, 1'b1);
    look("R6 neg reply clears 3", 3, 0);

    // R5: read waits behind older write to same block
    push(10, WR); push(10, RD);
    take("R5 write first", 10, WR);
    check("R5 read held", int'(mem_valid), 0);
    reply(10, 1'b0);
    take("R5 read after", 10, RD);
    reply(10, 1'b0);

    // R11: stray reply ignored
    push(20, PF);
    take("R11 issue 20", 20, PF);
    reply(21, 1'b0);
    look("R11 20 kept", 20, 1);
    reply(20, 1'b0);
    look("R11 20 gone", 20, 0);

    // R8: fill, refuse, free one, drain
    for (int i = 0; i < DEPTH; i++) push(100 + i, WR);
    check("R8 full not ready", int'(req_ready), 0);
    push(200, RD);
    look("R8 refused not held", 200, 0);
    take("R8 drain 100", 100, WR);
    reply(100, 1'b0);
    check("R8 ready after retire", int'(req_ready), 1);
    for (int i = 1; i < DEPTH; i++) begin
      take("R8 drain order", 100 + i, WR);
      reply(100 + i, 1'b0);
    end
    check("R8 empty", int'(mem_valid), 0);

    // R4 R9 sweep: n older writes then one read
    for (int n = 0; n <= 5; n++) begin
      for (int i = 0; i < n; i++) push(300 + i, WR);
      push(400, RD);
      take("R4 read ahead of writes", 400, RD);
      reply(400, 1'b0);
      for (int i = 0; i < n; i++) begin
        take("R9 writes in order", 300 + i, WR);
        reply(300 + i, 1'b0);
      end
      check("R4 sweep empty", int'(mem_valid), 0);
    end

    summary();
    $finish;
  end
endmodule